// File: doc/BRIEF.md
# Down-Counting Event Timer Channel

A single timer channel behind a simple 32-bit register port (address, write data, write strobe, read strobe, read data). Software loads an interval value and a current count, picks a tick source and a power-of-two prescaler, and enables the channel. While enabled, the count steps down once per prescaled tick. When it runs out, a pending flag is set and a level interrupt can be raised.

In periodic mode the count reloads from the interval and the channel keeps running. In one-shot mode the count stops at zero and the channel disables itself. The current count can be written apart from the interval, so the first expiry can come after a different delay than the later ones.

Top module: `evt_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Registers sit at these offsets: 0x00 interrupt enable (bit 0), 0x04 pending status (bit 0), 0x10 control, 0x14 interval, 0x18 current count. In control, bit 0 is run, bit 1 is periodic, bit 2 is source select and bits 6:4 are the prescaler code. Unused bits and unmapped offsets read 0, and `bus_rdata` is 0 while `bus_re` is low.
- R3: While run is set, the count drops by one on each prescaled tick. While run is clear, the count holds.
- R4: A prescaled tick that finds the count at 1 or 0 is an expiry, and the pending bit reads 1 from the next cycle on.
- R5: In periodic mode, expiry loads the interval into the count and leaves run set.
- R6: In one-shot mode, expiry leaves the count at 0 and clears run. The periodic bit always reads back as last written.
- R7: A write to the current count replaces it regardless of the interval. The first expiry follows after that many ticks, and later periods use the interval.
- R8: Prescaler code n passes one tick in 2^n. The divider restarts when run goes from 0 to 1 and advances only while run is set.
- R9: With source select at 1, `tick_osc` drives the channel. With it at 0, `tick_slow` does.
- R10: Writing 1 to status bit 0 clears the pending flag, and writing 0 has no effect. If an expiry falls in the same cycle as the clear, the flag stays set.
- R11: `irq` equals the pending flag AND interrupt-enable bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational |
| tick_slow | input | 1 | Tick source 0, one-cycle pulses |
| tick_osc | input | 1 | Tick source 1, one-cycle pulses |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: a 32-bit data path, an 8-bit address and a 3-bit prescaler code. Directed counts of a few ticks make expiry, reload, one-shot shutdown and the expiry-versus-clear collision happen within tens of cycles. One directed run uses code 2, so the divider restart on re-enable can be seen after only four ticks. The random phase keeps counts and intervals below 12 and prescaler codes at 3 or less, so expiries are frequent and often land on the same cycle as register writes.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int CODE_W = 3;

  localparam logic [7:0] OFS_IEN  = 8'h00;
  localparam logic [7:0] OFS_PEND = 8'h04;
  localparam logic [7:0] OFS_CTL  = 8'h10;
  localparam logic [7:0] OFS_IVL  = 8'h14;
  localparam logic [7:0] OFS_CNT  = 8'h18;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              src;
    logic              per;
    logic              run;
  } ctl_t;
endpackage

// File: rtl/evt_timer_div.sv
module evt_timer_div #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              run,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              hit
);
  localparam int DIV_W = (1 << CODE_W) - 1;

  logic [DIV_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim = ~({DIV_W{1'b1}} << code);
    hit = tick_in & run & (cnt_q >= lim);
    cnt_d = cnt_q;
    if (restart)             cnt_d = '0;
    else if (run && tick_in) cnt_d = hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/evt_timer_cnt.sv
module evt_timer_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         periodic,
  input  logic [W-1:0] interval,
  output logic [W-1:0] cur,
  output logic         expire
);
  logic [W-1:0] cur_q, cur_d;

  always_comb begin
    expire = step & (cur_q < W'(2));
    cur_d  = cur_q;
    if (load)      cur_d = load_val;
    else if (step) cur_d = expire ? (periodic ? interval : '0) : cur_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= cur_d;
  end

  assign cur = cur_q;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_slow,
  input  logic              tick_osc,
  output logic              irq
);
  localparam int CTL_W = $bits(ctl_t);

  logic [1:0] rsync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_i = rsync_q[1];

  logic ien_q, ien_d, pend_q, pend_d;
  ctl_t ctl_q, ctl_d;
  logic [DATA_W-1:0] ivl_q, ivl_d, cur;
  logic wr_ien, wr_pend, wr_ctl, wr_ivl, wr_cnt;
  logic tick_sel, step, expire, run_rise;

  always_comb begin
    wr_ien  = bus_we && (bus_addr == ADDR_W'(OFS_IEN));
    wr_pend = bus_we && (bus_addr == ADDR_W'(OFS_PEND));
    wr_ctl  = bus_we && (bus_addr == ADDR_W'(OFS_CTL));
    wr_ivl  = bus_we && (bus_addr == ADDR_W'(OFS_IVL));
    wr_cnt  = bus_we && (bus_addr == ADDR_W'(OFS_CNT));
  end

  assign tick_sel = ctl_q.src ? tick_osc : tick_slow;

  evt_timer_div #(.CODE_W(CODE_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .tick_in (tick_sel),
    .run     (ctl_q.run),
    .restart (run_rise),
    .code    (ctl_q.code),
    .hit     (step)
  );

  evt_timer_cnt #(.W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (wr_cnt),
    .load_val (bus_wdata),
    .step     (step),
    .periodic (ctl_q.per),
    .interval (ivl_q),
    .cur      (cur),
    .expire   (expire)
  );

  always_comb begin
    ien_d = wr_ien ? bus_wdata[0] : ien_q;
    ivl_d = wr_ivl ? bus_wdata : ivl_q;

    ctl_d = ctl_q;
    if (wr_ctl) begin
      ctl_d.run  = bus_wdata[0];
      ctl_d.per  = bus_wdata[1];
      ctl_d.src  = bus_wdata[2];
      ctl_d.code = bus_wdata[4 +: CODE_W];
    end else if (expire && !ctl_q.per) begin
      ctl_d.run = 1'b0;
    end
    run_rise = ctl_d.run & ~ctl_q.run;

    if (expire)                       pend_d = 1'b1;
    else if (wr_pend && bus_wdata[0]) pend_d = 1'b0;
    else                              pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ien_q  <= 1'b0;
      pend_q <= 1'b0;
      ctl_q  <= '0;
      ivl_q  <= '0;
    end else begin
      ien_q  <= ien_d;
      pend_q <= pend_d;
      ctl_q  <= ctl_d;
      ivl_q  <= ivl_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      unique case (bus_addr)
        ADDR_W'(OFS_IEN):  bus_rdata = DATA_W'(ien_q);
        ADDR_W'(OFS_PEND): bus_rdata = DATA_W'(pend_q);
        ADDR_W'(OFS_CTL):  bus_rdata = DATA_W'({ctl_q.code, 1'b0, ctl_q.src, ctl_q.per, ctl_q.run});
        ADDR_W'(OFS_IVL):  bus_rdata = ivl_q;
        ADDR_W'(OFS_CNT):  bus_rdata = cur;
        default:           bus_rdata = '0;
      endcase
    end
  end

  assign irq = pend_q & ien_q;

  logic unused_w;
  assign unused_w = ^{CTL_W[0]};
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              per,
  input logic              step,
  input logic              expire,
  input logic              cnt_wr,
  input logic              ctl_wr,
  input logic [DATA_W-1:0] cur,
  input logic [DATA_W-1:0] interval,
  input logic              pend,
  input logic              ien,
  input logic              irq
);
  AST_STEP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> run); // R8
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    step && !expire && !cnt_wr |=> cur == DATA_W'($past(cur) - 1'b1)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_wr |=> $stable(cur)); // R3
  AST_EXPIRE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend); // R4
  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    expire && per && !cnt_wr |=> cur == $past(interval)); // R5
  AST_PERIODIC_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    expire && per && !ctl_wr |=> run); // R5
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !per && !ctl_wr && !cnt_wr |=> !run && cur == '0); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq); // R11
endmodule

bind evt_timer evt_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_i),
  .run      (ctl_q.run),
  .per      (ctl_q.per),
  .step     (step),
  .expire   (expire),
  .cnt_wr   (wr_cnt),
  .ctl_wr   (wr_ctl),
  .cur      (cur),
  .interval (ivl_q),
  .pend     (pend_q),
  .ien      (ien_q),
  .irq      (irq)
);

// File: tb/test_evt_timer.sv
module test_evt_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_we, bus_re, tick_slow, tick_osc, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  evt_timer i_evt_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .tick_slow(tick_slow), .tick_osc(tick_osc), .irq(irq)
  );

  // reference state built from the requirements
  logic m_ien, m_pend, m_run, m_per, m_src;
  logic [2:0]  m_code;
  logic [31:0] m_ivl, m_cnt;
  int m_div;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return {31'b0, m_ien};
      8'h04: return {31'b0, m_pend};
      8'h10: return {25'b0, m_code, 1'b0, m_src, m_per, m_run};
      8'h14: return m_ivl;
      8'h18: return m_cnt;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d,
                      input bit re, input bit ts, input bit to, input string tag);
    bit sel, hit, ex, n_run;
    int lim;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; bus_re = re;
    tick_slow = ts; tick_osc = to;
    #1;
    if (re) chk(tag, bus_rdata, m_read(a));
    else    chk("R2 idle rdata", bus_rdata, 32'h0);
    chk("R11 irq", {31'b0, irq}, {31'b0, m_pend & m_ien});
    sel = m_src ? to : ts;
    lim = (1 << m_code) - 1;
    hit = m_run && sel && (m_div >= lim);
    ex  = hit && (m_cnt <= 1);
    @(posedge clk);
    n_run = m_run;
    if (we && a == 8'h10) n_run = d[0];
    else if (ex && !m_per) n_run = 1'b0;
    if (!m_run && n_run) m_div = 0;
    else if (m_run && sel) m_div = hit ? 0 : m_div + 1;
    if (we && a == 8'h18) m_cnt = d;
    else if (hit) m_cnt = ex ? (m_per ? m_ivl : 32'h0) : m_cnt - 1;
    if (ex) m_pend = 1'b1;
    else if (we && a == 8'h04 && d[0]) m_pend = 1'b0;
    if (we && a == 8'h10) begin
      m_per = d[1]; m_src = d[2]; m_code = d[6:4];
    end
    m_run = n_run;
    if (we && a == 8'h00) m_ien = d[0];
    if (we && a == 8'h14) m_ivl = d;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1, a, d, 0, 0, 0, "");
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    step(0, a, 0, 1, 0, 0, tag);
  endtask
  task automatic rdx(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd(a, tag);
    chk(tag, m_read(a), exp); // reference agrees with hand-worked value
  endtask
  task automatic ticks(input int n, input bit osc);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, !osc, osc, "");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_ien = 0; m_pend = 0; m_run = 0; m_per = 0; m_src = 0; m_code = 0;
    m_ivl = 0; m_cnt = 0; m_div = 0;
    bus_we = 0; bus_re = 0; bus_addr = 0; bus_wdata = 0; tick_slow = 0; tick_osc = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);

    // R1 reset values
    rdx(8'h00, 0, "R1 ien"); rdx(8'h04, 0, "R1 pend"); rdx(8'h10, 0, "R1 ctl");
    rdx(8'h14, 0, "R1 ivl"); rdx(8'h18, 0, "R1 cnt");

    // R2 register map
    wr(8'h14, 32'h1234_5678); wr(8'h18, 32'h0000_abcd); wr(8'h10, 32'hffff_ff76);
    rdx(8'h14, 32'h1234_5678, "R2 ivl"); rdx(8'h18, 32'h0000_abcd, "R2 cnt");
    rdx(8'h10, 32'h76, "R2 ctl"); rdx(8'h0c, 0, "R2 unmapped");
    wr(8'h10, 0);

    // R3 R4 R6 one-shot
    wr(8'h00, 1); wr(8'h18, 3); wr(8'h10, 32'h1);
    ticks(2, 0);
    rdx(8'h18, 1, "R3 count"); rdx(8'h04, 0, "R4 not yet");
    ticks(1, 0);
    rdx(8'h04, 1, "R4 pend"); rdx(8'h18, 0, "R6 count"); rdx(8'h10, 0, "R6 run off");
    ticks(3, 0);
    rdx(8'h18, 0, "R3 hold");
    chk("R11 irq up", {31'b0, irq}, 32'h1);

    // R10 clear semantics
    wr(8'h04, 0); rdx(8'h04, 1, "R10 write0");
    wr(8'h04, 1); rdx(8'h04, 0, "R10 write1");
    wr(8'h18, 1); wr(8'h10, 32'h3);
    step(1, 8'h04, 1, 0, 1, 0, "");
    rdx(8'h04, 1, "R10 collision");

    // R5 R7 periodic with distinct first expiry
    wr(8'h10, 0); wr(8'h04, 1);
    wr(8'h14, 4); wr(8'h18, 2); wr(8'h10, 32'h3);
    ticks(2, 0);
    rdx(8'h04, 1, "R7 first"); rdx(8'h18, 4, "R5 reload");
    wr(8'h04, 1);
    ticks(3, 0); rdx(8'h04, 0, "R7 period");
    ticks(1, 0);
    rdx(8'h04, 1, "R5 second"); rdx(8'h10, 32'h3, "R5 still run");

    // R8 prescaler and restart
    wr(8'h10, 0); wr(8'h18, 100); wr(8'h10, 32'h21);
    ticks(8, 0); rdx(8'h18, 98, "R8 div4");
    ticks(3, 0); wr(8'h10, 32'h20); wr(8'h10, 32'h21);
    ticks(3, 0); rdx(8'h18, 98, "R8 restart");
    ticks(1, 0); rdx(8'h18, 97, "R8 after");

    // R9 source select
    wr(8'h10, 0); wr(8'h18, 50); wr(8'h10, 32'h5);
    ticks(5, 0); rdx(8'h18, 50, "R9 slow ignored");
    ticks(5, 1); rdx(8'h18, 45, "R9 osc");

    // random phase against the reference
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [7:0] a;
      logic [31:0] d;
      r = int'($urandom % 16);
      case ($urandom % 6)
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h10;
        3: a = 8'h14; 4: a = 8'h18; default: a = 8'h0c;
      endcase
      d = (a == 8'h10) ? ($urandom & 32'h37) :
          (a == 8'h14 || a == 8'h18) ? ($urandom % 12) : $urandom;
      if (r < 2 && a != 8'h0c) step(1, a, d, 0, $urandom % 2 == 0, $urandom % 3 == 0, "");
      else if (r < 6)          step(0, a, 0, 1, $urandom % 2 == 0, $urandom % 3 == 0, "R2 random read");
      else                     step(0, 8'h00, 0, 0, $urandom % 2 == 0, $urandom % 3 == 0, "");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule